// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block collects the local interrupt requests of a four-core cluster and turns them into one active-low IRQ line and one active-low FIQ line per core. Each core has four private timer request lines and four private mailbox request lines. Each of these lines carries its own IRQ enable and its own FIQ enable, held in a per-core control register. Two request lines are shared by all cores: the graphics-side interrupt and the performance-monitor interrupt. The graphics IRQ request and the graphics FIQ request are each sent to one core, picked by a routing register. The performance-monitor request goes, as an IRQ, to every core whose enable bit is set. Software changes those enable bits through separate write-to-set and write-to-clear addresses.

Software reaches the block over a simple 32-bit register port. A write takes effect on the clock edge where `reg_wr` is high. Read data is a combinational function of `reg_addr`. For every core the block shows an IRQ-pending word and an FIQ-pending word. Both words use the same bit layout and follow the request inputs with no delay. Each core output is registered from the OR of that core's pending word, so it changes one clock after the request.

Top module: `core_irq_router`

## Requirements
- R1: After reset every control register reads zero, both graphics routing fields select core 0, and every `core_irq_n` and `core_fiq_n` bit is high. This holds even while all timer, mailbox and performance-monitor requests are high.
- R2: The per-core timer control (0x040 + 4·core) and mailbox control (0x050 + 4·core) registers read back bits [7:0] as written. The routing register (0x00C) reads back bits [3:0] as written. All higher bits read zero.
- R3: Timer source s of core c is `tmr_req[4c+s]`. When control bit s is set and bit s+4 is clear, the request shows in bit s of the core's IRQ-pending word (0x060 + 4·core) and not in its FIQ-pending word (0x070 + 4·core).
- R4: When a source's FIQ enable (control bit s+4) is set, the source shows in the FIQ-pending word and never in the IRQ-pending word, whatever its IRQ enable (control bit s) holds.
- R5: Mailbox source m of core c is `mbx_req[4c+m]`. It is enabled by bits m and m+4 of the mailbox control register, and it appears in bit 4+m of the pending words, with the same precedence as timers.
- R6: `gpu_irq_req` appears in bit 8 of the IRQ-pending word of exactly the core named by routing bits [1:0], and of no other core.
- R7: `gpu_fiq_req` appears in bit 8 of the FIQ-pending word of exactly the core named by routing bits [3:2], and of no other core.
- R8: A write to 0x010 sets the performance-monitor enable of each core n whose data bit n is 1. A write to 0x014 clears it. Zero data bits leave the enables unchanged. Both addresses read the enable mask in bits [3:0]. When `pmu_req` is high, bit 9 of every enabled core's IRQ-pending word is set. FIQ-pending bit 9 is always zero.
- R9: Writes to the pending words are ignored, and reads of them change nothing. Control registers and pending words are the same afterwards.
- R10: `core_irq_n[c]` is low exactly one clock after the IRQ-pending word of core c is nonzero. `core_fiq_n[c]` behaves the same way for the FIQ-pending word.
- R11: A request whose two enables are both clear appears in no pending word and drives no output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| tmr_req | input | 16 | Timer requests, index 4·core + source |
| mbx_req | input | 16 | Mailbox requests, index 4·core + mailbox |
| gpu_irq_req | input | 1 | Shared graphics IRQ request |
| gpu_fiq_req | input | 1 | Shared graphics FIQ request |
| pmu_req | input | 1 | Shared performance-monitor request |
| core_irq_n | output | 4 | Active-low IRQ per core |
| core_fiq_n | output | 4 | Active-low FIQ per core |

## Verification
The hardest case to reach is one source whose IRQ and FIQ enables are both set. The override only shows when the IRQ path would otherwise also fire. The stimulus writes a control value with both bits set and holds the request high. It then expects the FIQ line low and the IRQ line high on the same core. A second hard case is the graphics routing: a correct result can hide a decode that also hits other cores. For that reason, every routing value is stepped through and all four cores are checked each time, not only the core that should be selected.

// File: rtl/core_irq_pkg.sv
package core_irq_pkg;
  // register offsets
  localparam int OFS_GPU_ROUTE = 'h00C;
  localparam int OFS_PMU_SET   = 'h010;
  localparam int OFS_PMU_CLR   = 'h014;
  localparam int OFS_TMR_CTL   = 'h040;
  localparam int OFS_MBX_CTL   = 'h050;
  localparam int OFS_IRQ_STAT  = 'h060;
  localparam int OFS_FIQ_STAT  = 'h070;

  localparam int SRC_N  = 4;          // sources per group
  localparam int CTL_W  = 2 * SRC_N;  // IRQ enables + FIQ enables
  localparam int STAT_W = 10;         // pending word width
  localparam int BIT_GPU = 8;
  localparam int BIT_PMU = 9;

  // a source raises FIQ when its FIQ enable is set
  function automatic logic [SRC_N-1:0] fiq_pick(input logic [SRC_N-1:0] req,
                                                input logic [CTL_W-1:0] ctl);
    return req & ctl[CTL_W-1:SRC_N];
  endfunction

  // IRQ only when its IRQ enable is set and FIQ does not override
  function automatic logic [SRC_N-1:0] irq_pick(input logic [SRC_N-1:0] req,
                                                input logic [CTL_W-1:0] ctl);
    return req & ctl[SRC_N-1:0] & ~ctl[CTL_W-1:SRC_N];
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import core_irq_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int AW     = 8,
  parameter int DW     = 32,
  localparam int RW    = $clog2(NCORES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wdata,
  output logic [NCORES*CTL_W-1:0] tmr_ctl,
  output logic [NCORES*CTL_W-1:0] mbx_ctl,
  output logic [2*RW-1:0]         gpu_route,
  output logic [NCORES-1:0]       pmu_en
);
  logic hit_route, hit_set, hit_clr;
  assign hit_route = wr && (addr == AW'(OFS_GPU_ROUTE));
  assign hit_set   = wr && (addr == AW'(OFS_PMU_SET));
  assign hit_clr   = wr && (addr == AW'(OFS_PMU_CLR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpu_route <= '0;
      pmu_en    <= '0;
    end else begin
      if (hit_route) gpu_route <= wdata[2*RW-1:0];
      if (hit_set)   pmu_en    <= pmu_en | wdata[NCORES-1:0];
      else if (hit_clr) pmu_en <= pmu_en & ~wdata[NCORES-1:0];
    end
  end

  for (genvar c = 0; c < NCORES; c++) begin : g_ctl
    logic hit_t, hit_m;
    assign hit_t = wr && (addr == AW'(OFS_TMR_CTL + 4 * c));
    assign hit_m = wr && (addr == AW'(OFS_MBX_CTL + 4 * c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tmr_ctl[c*CTL_W +: CTL_W] <= '0;
        mbx_ctl[c*CTL_W +: CTL_W] <= '0;
      end else begin
        if (hit_t) tmr_ctl[c*CTL_W +: CTL_W] <= wdata[CTL_W-1:0];
        if (hit_m) mbx_ctl[c*CTL_W +: CTL_W] <= wdata[CTL_W-1:0];
      end
    end
  end
endmodule

// File: rtl/irq_core_slice.sv
module irq_core_slice
  import core_irq_pkg::*;
#(
  parameter int NCORES  = 4,
  parameter int CORE_ID = 0,
  localparam int RW     = $clog2(NCORES)
) (
  input  logic [SRC_N-1:0]  tmr_req,
  input  logic [SRC_N-1:0]  mbx_req,
  input  logic [CTL_W-1:0]  tmr_ctl,
  input  logic [CTL_W-1:0]  mbx_ctl,
  input  logic              gpu_irq,
  input  logic              gpu_fiq,
  input  logic [2*RW-1:0]   gpu_route,
  input  logic              pmu_req,
  input  logic              pmu_en,
  output logic [STAT_W-1:0] irq_pend,
  output logic [STAT_W-1:0] fiq_pend
);
  logic gpu_irq_mine, gpu_fiq_mine;
  assign gpu_irq_mine = gpu_irq && (gpu_route[RW-1:0]    == RW'(CORE_ID));
  assign gpu_fiq_mine = gpu_fiq && (gpu_route[2*RW-1:RW] == RW'(CORE_ID));

  assign irq_pend = {pmu_req & pmu_en, gpu_irq_mine,
                     irq_pick(mbx_req, mbx_ctl), irq_pick(tmr_req, tmr_ctl)};
  assign fiq_pend = {1'b0, gpu_fiq_mine,
                     fiq_pick(mbx_req, mbx_ctl), fiq_pick(tmr_req, tmr_ctl)};
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import core_irq_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int AW     = 8,
  parameter int DW     = 32,
  localparam int RW    = $clog2(NCORES)
) (
  input  logic [AW-1:0]            addr,
  input  logic [NCORES*CTL_W-1:0]  tmr_ctl,
  input  logic [NCORES*CTL_W-1:0]  mbx_ctl,
  input  logic [2*RW-1:0]          gpu_route,
  input  logic [NCORES-1:0]        pmu_en,
  input  logic [NCORES*STAT_W-1:0] irq_pend,
  input  logic [NCORES*STAT_W-1:0] fiq_pend,
  output logic [DW-1:0]            rdata
);
  always_comb begin
    rdata = '0;
    if (addr == AW'(OFS_GPU_ROUTE)) rdata = DW'(gpu_route);
    if (addr == AW'(OFS_PMU_SET) || addr == AW'(OFS_PMU_CLR)) rdata = DW'(pmu_en);
    for (int c = 0; c < NCORES; c++) begin
      if (addr == AW'(OFS_TMR_CTL + 4 * c))  rdata = DW'(tmr_ctl[c*CTL_W +: CTL_W]);
      if (addr == AW'(OFS_MBX_CTL + 4 * c))  rdata = DW'(mbx_ctl[c*CTL_W +: CTL_W]);
      if (addr == AW'(OFS_IRQ_STAT + 4 * c)) rdata = DW'(irq_pend[c*STAT_W +: STAT_W]);
      if (addr == AW'(OFS_FIQ_STAT + 4 * c)) rdata = DW'(fiq_pend[c*STAT_W +: STAT_W]);
    end
  end
endmodule

// File: rtl/core_irq_router.sv
module core_irq_router
  import core_irq_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int AW     = 8,
  parameter int DW     = 32,
  localparam int RW    = $clog2(NCORES),
  localparam int REQ_W = NCORES * SRC_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [REQ_W-1:0]  tmr_req,
  input  logic [REQ_W-1:0]  mbx_req,
  input  logic              gpu_irq_req,
  input  logic              gpu_fiq_req,
  input  logic              pmu_req,
  output logic [NCORES-1:0] core_irq_n,
  output logic [NCORES-1:0] core_fiq_n
);
  logic [NCORES*CTL_W-1:0]  tmr_ctl, mbx_ctl;
  logic [2*RW-1:0]          gpu_route;
  logic [NCORES-1:0]        pmu_en;
  logic [NCORES*STAT_W-1:0] irq_pend_all, fiq_pend_all;
  logic [NCORES-1:0]        irq_any, fiq_any;

  irq_cfg_regs #(.NCORES(NCORES), .AW(AW), .DW(DW)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .tmr_ctl(tmr_ctl), .mbx_ctl(mbx_ctl), .gpu_route(gpu_route), .pmu_en(pmu_en)
  );

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    irq_core_slice #(.NCORES(NCORES), .CORE_ID(c)) slice_i (
      .tmr_req(tmr_req[c*SRC_N +: SRC_N]), .mbx_req(mbx_req[c*SRC_N +: SRC_N]),
      .tmr_ctl(tmr_ctl[c*CTL_W +: CTL_W]), .mbx_ctl(mbx_ctl[c*CTL_W +: CTL_W]),
      .gpu_irq(gpu_irq_req), .gpu_fiq(gpu_fiq_req), .gpu_route(gpu_route),
      .pmu_req(pmu_req), .pmu_en(pmu_en[c]),
      .irq_pend(irq_pend_all[c*STAT_W +: STAT_W]),
      .fiq_pend(fiq_pend_all[c*STAT_W +: STAT_W])
    );
    assign irq_any[c] = |irq_pend_all[c*STAT_W +: STAT_W];
    assign fiq_any[c] = |fiq_pend_all[c*STAT_W +: STAT_W];
  end

  irq_read_mux #(.NCORES(NCORES), .AW(AW), .DW(DW)) rd_i (
    .addr(reg_addr), .tmr_ctl(tmr_ctl), .mbx_ctl(mbx_ctl), .gpu_route(gpu_route),
    .pmu_en(pmu_en), .irq_pend(irq_pend_all), .fiq_pend(fiq_pend_all), .rdata(reg_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_irq_n <= '1;
      core_fiq_n <= '1;
    end else begin
      core_irq_n <= ~irq_any;
      core_fiq_n <= ~fiq_any;
    end
  end
endmodule

// File: rtl/core_irq_router_chk.sv
module core_irq_router_chk
  import core_irq_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int AW     = 8,
  parameter int DW     = 32,
  localparam int RW    = $clog2(NCORES)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_wr,
  input logic [AW-1:0]            reg_addr,
  input logic [DW-1:0]            reg_wdata,
  input logic [NCORES-1:0]        core_irq_n,
  input logic [NCORES-1:0]        core_fiq_n,
  input logic [NCORES-1:0]        irq_any,
  input logic [NCORES-1:0]        fiq_any,
  input logic [NCORES-1:0]        pmu_en,
  input logic [2*RW-1:0]          gpu_route,
  input logic [NCORES*STAT_W-1:0] irq_pend_all,
  input logic [NCORES*STAT_W-1:0] fiq_pend_all
);
  logic [NCORES-1:0] gpu_irq_col, gpu_fiq_col;
  logic              src_overlap;
  always_comb begin
    src_overlap = 1'b0;
    for (int c = 0; c < NCORES; c++) begin
      gpu_irq_col[c] = irq_pend_all[c*STAT_W + BIT_GPU];
      gpu_fiq_col[c] = fiq_pend_all[c*STAT_W + BIT_GPU];
      src_overlap = src_overlap |
        (|(irq_pend_all[c*STAT_W +: CTL_W] & fiq_pend_all[c*STAT_W +: CTL_W]));
    end
  end

  // R1
  reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pmu_en == '0) && (gpu_route == '0) && (&core_irq_n) && (&core_fiq_n));
  // R4
  no_dual_chk: assert property (@(posedge clk) disable iff (!rst_n) !src_overlap);
  // R6
  gpu_irq_one_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gpu_irq_col));
  // R7
  gpu_fiq_one_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gpu_fiq_col));
  // R8
  pmu_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(OFS_PMU_SET)) |=>
      ((pmu_en & $past(reg_wdata[NCORES-1:0])) == $past(reg_wdata[NCORES-1:0])));
  // R8
  pmu_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(OFS_PMU_CLR)) |=>
      ((pmu_en & $past(reg_wdata[NCORES-1:0])) == '0));
  // R10
  irq_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (core_irq_n == ~$past(irq_any)));
  // R10
  fiq_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (core_fiq_n == ~$past(fiq_any)));
endmodule

bind core_irq_router core_irq_router_chk #(.NCORES(NCORES), .AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .core_irq_n(core_irq_n), .core_fiq_n(core_fiq_n), .irq_any(irq_any), .fiq_any(fiq_any),
  .pmu_en(pmu_en), .gpu_route(gpu_route), .irq_pend_all(irq_pend_all),
  .fiq_pend_all(fiq_pend_all)
);

// File: tb/core_irq_router_tb_top.sv
`timescale 1ns/1ps
module core_irq_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] tmr_req = '0;
  logic [15:0] mbx_req = '0;
  logic        gpu_irq_req = 1'b0, gpu_fiq_req = 1'b0, pmu_req = 1'b0;
  logic [3:0]  core_irq_n, core_fiq_n;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;  // 250 MHz

  core_irq_router dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_req(tmr_req),
    .mbx_req(mbx_req), .gpu_irq_req(gpu_irq_req), .gpu_fiq_req(gpu_fiq_req),
    .pmu_req(pmu_req), .core_irq_n(core_irq_n), .core_fiq_n(core_fiq_n)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // wait for the output register to take the present pending state
  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic clear_all();
    tmr_req = '0; mbx_req = '0; gpu_irq_req = 0; gpu_fiq_req = 0; pmu_req = 0;
    for (int c = 0; c < 4; c++) begin
      wr(8'h40 + 8'(4*c), 0); wr(8'h50 + 8'(4*c), 0);
    end
    wr(8'h0C, 0); wr(8'h14, 32'hF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    tmr_req = '1; mbx_req = '1; pmu_req = 1;
    for (int c = 0; c < 4; c++) begin
      rd(8'h40 + 8'(4*c), d); chk("R1 timer ctl", d, 0);
      rd(8'h50 + 8'(4*c), d); chk("R1 mailbox ctl", d, 0);
      rd(8'h60 + 8'(4*c), d); chk("R1 irq pend", d, 0);
    end
    rd(8'h0C, d); chk("R1 route", d, 0);
    rd(8'h10, d); chk("R1 pmu mask", d, 0);
    settle();
    chk("R1 irq_n", 32'(core_irq_n), 32'hF);
    chk("R1 fiq_n", 32'(core_fiq_n), 32'hF);
    tmr_req = '0; mbx_req = '0; pmu_req = 0;
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(8'h48, 32'hFFFF_FFFF); rd(8'h48, d); chk("R2 timer ctl", d, 32'hFF);
    wr(8'h54, 32'h1234_56A5); rd(8'h54, d); chk("R2 mailbox ctl", d, 32'hA5);
    wr(8'h0C, 32'hFFFF_FFF6); rd(8'h0C, d); chk("R2 route", d, 32'h6);
    clear_all();
  endtask

  task automatic t_timer_irq();
    logic [31:0] d;
    wr(8'h44, 32'h04);            // core1: hypervisor timer IRQ enable
    tmr_req[1*4+2] = 1'b1;
    rd(8'h64, d); chk("R3 irq pend", d, 32'h004);
    rd(8'h74, d); chk("R3 fiq pend", d, 0);
    settle();
    chk("R10 irq_n", 32'(core_irq_n), 32'hD);
    chk("R10 fiq_n", 32'(core_fiq_n), 32'hF);
    // R4: add the FIQ enable for the same source
    wr(8'h44, 32'h44);
    rd(8'h64, d); chk("R4 irq pend", d, 0);
    rd(8'h74, d); chk("R4 fiq pend", d, 32'h004);
    settle();
    chk("R4 irq_n", 32'(core_irq_n), 32'hF);
    chk("R4 fiq_n", 32'(core_fiq_n), 32'hD);
    tmr_req = '0;
    settle();
    chk("R10 release", 32'(core_fiq_n), 32'hF);
    clear_all();
  endtask

  task automatic t_mailbox();
    logic [31:0] d;
    wr(8'h5C, 32'h21);            // core3: mb0 IRQ, mb1 FIQ
    mbx_req[3*4+0] = 1; mbx_req[3*4+1] = 1; mbx_req[3*4+3] = 1;
    rd(8'h6C, d); chk("R5 irq pend", d, 32'h010);
    rd(8'h7C, d); chk("R5 fiq pend", d, 32'h020);
    settle();
    chk("R5 irq_n", 32'(core_irq_n), 32'h7);
    chk("R5 fiq_n", 32'(core_fiq_n), 32'h7);
    clear_all();
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    tmr_req = '1; mbx_req = '1;
    wr(8'h40, 32'h0);
    rd(8'h60, d); chk("R11 irq pend", d, 0);
    rd(8'h70, d); chk("R11 fiq pend", d, 0);
    settle();
    chk("R11 irq_n", 32'(core_irq_n), 32'hF);
    chk("R11 fiq_n", 32'(core_fiq_n), 32'hF);
    clear_all();
  endtask

  task automatic t_gpu();
    logic [31:0] d;
    gpu_irq_req = 1; gpu_fiq_req = 1;
    for (int r = 0; r < 4; r++) begin
      wr(8'h0C, 32'(r | ((3 - r) << 2)));
      for (int c = 0; c < 4; c++) begin
        rd(8'h60 + 8'(4*c), d); chk("R6 gpu irq", d, (c == r) ? 32'h100 : 0);
        rd(8'h70 + 8'(4*c), d); chk("R7 gpu fiq", d, (c == 3 - r) ? 32'h100 : 0);
      end
    end
    clear_all();
  endtask

  task automatic t_pmu();
    logic [31:0] d;
    pmu_req = 1;
    wr(8'h10, 32'h5); rd(8'h10, d); chk("R8 set", d, 32'h5);
    wr(8'h10, 32'h2); rd(8'h14, d); chk("R8 set or", d, 32'h7);
    wr(8'h14, 32'h4); rd(8'h10, d); chk("R8 clr", d, 32'h3);
    wr(8'h14, 32'h0); rd(8'h10, d); chk("R8 clr zero", d, 32'h3);
    rd(8'h60, d); chk("R8 pend core0", d, 32'h200);
    rd(8'h68, d); chk("R8 pend core2", d, 0);
    rd(8'h70, d); chk("R8 fiq pend", d, 0);
    settle();
    chk("R8 irq_n", 32'(core_irq_n), 32'hC);
    clear_all();
  endtask

  task automatic t_status_write();
    logic [31:0] d;
    wr(8'h40, 32'h01); tmr_req[0] = 1;
    wr(8'h60, 32'hFFFF_FFFF); wr(8'h70, 32'hFFFF_FFFF);
    rd(8'h60, d); chk("R9 irq pend kept", d, 32'h001);
    rd(8'h60, d); chk("R9 reread", d, 32'h001);
    rd(8'h70, d); chk("R9 fiq pend kept", d, 0);
    rd(8'h40, d); chk("R9 ctl kept", d, 32'h01);
    rd(8'h0C, d); chk("R9 route kept", d, 0);
    rd(8'h10, d); chk("R9 pmu kept", d, 0);
    clear_all();
  endtask

  initial begin
    #(4 * 200000);
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_timer_irq();
    t_mailbox();
    t_disabled();
    t_gpu();
    t_pmu();
    t_status_write();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule